// File: doc/BRIEF.md
# Fixed-Priority Cache-Fill and Write-Burst Arbiter

This block chooses which of three internal requesters may use a shared 64-bit internal data path, then moves one 32-byte block across that path as four 64-bit beats. The requesters are the data-cache fill, the instruction-cache fill and the write buffer. When a fill is granted, data flows from the external side into the cache that owns the grant. When a write is granted, data flows from the write buffer out to the external side.

Requests are level signals. A requester holds its request until it sees its own done pulse. The external side is a plain beat port: while a burst is active, `xfer_act` is high, and each cycle with `ext_rdy` high moves one beat. Once a grant is issued it stays locked until all four beats have moved. In the cycle after the last beat, the arbiter emits a done pulse and picks the next requester.

Top module: `fwarb_top`

## Requirements
- R1: While `rst` is high, every grant, every done line, `xfer_act`, `cache_we` and `wbuf_pop` are low, and `bus_dir` is 2'b00.
- R2: At most one of the three grant outputs is high in any cycle.
- R3: When more than one request is pending in an arbitration cycle, the grant goes to the data-cache fill first, then the instruction-cache fill, then the write buffer.
- R4: A request that is present in a cycle with no active burst is granted in the next cycle.
- R5: `beat_idx` starts at 0 when a grant is issued and moves up by one only in a cycle where `ext_rdy` is high. A burst ends after exactly four accepted beats. In a cycle with `ext_rdy` low, `beat_idx` holds and neither data strobe is raised.
- R6: A grant stays unchanged until its fourth beat is accepted, even if a higher-priority request arrives during the burst.
- R7: In the cycle after the fourth beat, the done line of the class that held the grant is high for exactly one cycle, and all grants are low in that cycle.
- R8: During a fill grant, `bus_dir` is 2'b01 and `cache_wdata` equals `ext_rdata`, with `cache_we` high on each accepted beat. During a write-buffer grant, `bus_dir` is 2'b10 and `ext_wdata` equals `wbuf_data`, with `wbuf_pop` high on each accepted beat.
- R9: Arbitration takes place in the done cycle. If requests are pending, the next grant appears in the cycle right after the done pulse.
- R10: With no grant active, `bus_dir` is 2'b00 and `xfer_act`, `cache_we` and `wbuf_pop` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dfill_req | input | 1 | Data-cache fill request (level) |
| ifill_req | input | 1 | Instruction-cache fill request (level) |
| wbuf_req | input | 1 | Write-buffer write request (level) |
| dfill_gnt | output | 1 | Data-cache fill grant |
| ifill_gnt | output | 1 | Instruction-cache fill grant |
| wbuf_gnt | output | 1 | Write-buffer grant |
| dfill_done | output | 1 | One-cycle end-of-burst pulse, data-cache fill |
| ifill_done | output | 1 | One-cycle end-of-burst pulse, instruction-cache fill |
| wbuf_done | output | 1 | One-cycle end-of-burst pulse, write buffer |
| ext_rdy | input | 1 | External side moves one beat this cycle |
| ext_rdata | input | 64 | Fill data from the external side |
| wbuf_data | input | 64 | Write data from the write buffer |
| xfer_act | output | 1 | A burst is in progress |
| bus_dir | output | 2 | 00 idle, 01 toward cache, 10 toward external side |
| beat_idx | output | 2 | Index of the current beat within the burst |
| cache_wdata | output | 64 | Fill data toward the granted cache |
| cache_we | output | 1 | Fill beat strobe for the granted cache |
| wbuf_pop | output | 1 | Write beat consumed from the write buffer |
| ext_wdata | output | 64 | Write data toward the external side |

## Verification
The arbiter is exercised with several request patterns. A lone data fill with no stalls shows the grant latency and the clean four-beat burst. A lone write with `ext_rdy` stalling at random checks the beat hold and that the direction flips toward the external side. Three simultaneous requests show priority order and back-to-back re-arbitration. A data fill that arrives during a write burst separates true burst locking from preemption. Instruction fill and write together check the middle priority level, and a quiet stretch confirms the idle bus state.

// File: rtl/fwarb_pkg.sv
package fwarb_pkg;

  localparam int NREQ  = 3;
  localparam int REQ_D = 0;
  localparam int REQ_I = 1;
  localparam int REQ_W = 2;

  typedef enum logic [1:0] {
    DIR_IDLE     = 2'b00,
    DIR_TO_CACHE = 2'b01,
    DIR_TO_EXT   = 2'b10
  } xfer_dir_e;

  function automatic xfer_dir_e dir_for(input logic [NREQ-1:0] sel);
    if (sel[REQ_W])                   return DIR_TO_EXT;
    else if (sel[REQ_D] | sel[REQ_I]) return DIR_TO_CACHE;
    else                              return DIR_IDLE;
  endfunction

endpackage

// File: rtl/fwarb_prio.sv
module fwarb_prio #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pick_o
);

  logic [N-1:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_lvl
    assign pick_o[i] = req_i[i] & ~taken[i];
    if (i < N - 1) begin : g_chain
      assign taken[i+1] = taken[i] | req_i[i];
    end
  end

endmodule

// File: rtl/fwarb_beat_ctr.sv
module fwarb_beat_ctr #(
  parameter int BEATS = 4,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/fwarb_datapath.sv
module fwarb_datapath
  import fwarb_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  xfer_dir_e         dir_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] ext_rdata_i,
  input  logic [DATA_W-1:0] wbuf_data_i,
  output logic [DATA_W-1:0] cache_wdata_o,
  output logic              cache_we_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  output logic              wbuf_pop_o
);

  logic to_cache, to_ext;

  assign to_cache = (dir_i == DIR_TO_CACHE);
  assign to_ext   = (dir_i == DIR_TO_EXT);

  always_comb begin
    cache_wdata_o = to_cache ? ext_rdata_i : '0;
    ext_wdata_o   = to_ext   ? wbuf_data_i : '0;
    cache_we_o    = to_cache & step_i;
    wbuf_pop_o    = to_ext   & step_i;
  end

endmodule

// File: rtl/fwarb_top.sv
module fwarb_top
  import fwarb_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int BLOCK_BYTES = 32,
  localparam int BEATS      = BLOCK_BYTES / (DATA_W / 8),
  localparam int CNT_W      = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dfill_req,
  input  logic              ifill_req,
  input  logic              wbuf_req,
  output logic              dfill_gnt,
  output logic              ifill_gnt,
  output logic              wbuf_gnt,
  output logic              dfill_done,
  output logic              ifill_done,
  output logic              wbuf_done,
  input  logic              ext_rdy,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic [DATA_W-1:0] wbuf_data,
  output logic              xfer_act,
  output logic [1:0]        bus_dir,
  output logic [CNT_W-1:0]  beat_idx,
  output logic [DATA_W-1:0] cache_wdata,
  output logic              cache_we,
  output logic              wbuf_pop,
  output logic [DATA_W-1:0] ext_wdata
);

  logic [NREQ-1:0] req_vec;
  logic [NREQ-1:0] pick;
  logic [NREQ-1:0] gnt_q;
  logic [NREQ-1:0] done_q;
  xfer_dir_e       dir_q;
  logic            active;
  logic            step;
  logic            last_beat;

  assign req_vec[REQ_D] = dfill_req;
  assign req_vec[REQ_I] = ifill_req;
  assign req_vec[REQ_W] = wbuf_req;

  // index 0 wins: data fill, then instruction fill, then write buffer
  fwarb_prio #(.N(NREQ)) u_prio (
    .req_i  (req_vec),
    .pick_o (pick)
  );

  assign active = |gnt_q;
  assign step   = active & ext_rdy;

  fwarb_beat_ctr #(.BEATS(BEATS)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .step_i (step),
    .cnt_o  (beat_idx),
    .last_o (last_beat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      done_q <= '0;
      dir_q  <= DIR_IDLE;
    end else begin
      done_q <= '0;
      if (!active) begin
        gnt_q <= pick;
        dir_q <= dir_for(pick);
      end else if (step && last_beat) begin
        gnt_q  <= '0;
        done_q <= gnt_q;
        dir_q  <= DIR_IDLE;
      end
    end
  end

  fwarb_datapath #(.DATA_W(DATA_W)) u_dp (
    .dir_i         (dir_q),
    .step_i        (step),
    .ext_rdata_i   (ext_rdata),
    .wbuf_data_i   (wbuf_data),
    .cache_wdata_o (cache_wdata),
    .cache_we_o    (cache_we),
    .ext_wdata_o   (ext_wdata),
    .wbuf_pop_o    (wbuf_pop)
  );

  assign dfill_gnt  = gnt_q[REQ_D];
  assign ifill_gnt  = gnt_q[REQ_I];
  assign wbuf_gnt   = gnt_q[REQ_W];
  assign dfill_done = done_q[REQ_D];
  assign ifill_done = done_q[REQ_I];
  assign wbuf_done  = done_q[REQ_W];
  assign xfer_act   = active;
  assign bus_dir    = dir_q;

endmodule

// File: rtl/fwarb_checker.sv
module fwarb_checker #(
  parameter int BEATS = 4,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             dfill_req,
  input logic             ifill_req,
  input logic             dfill_gnt,
  input logic             ifill_gnt,
  input logic             wbuf_gnt,
  input logic             dfill_done,
  input logic             ifill_done,
  input logic             wbuf_done,
  input logic             ext_rdy,
  input logic             xfer_act,
  input logic [1:0]       bus_dir,
  input logic [CNT_W-1:0] beat_idx,
  input logic             cache_we,
  input logic             wbuf_pop
);

  logic [2:0] g;
  logic [2:0] d;
  logic       at_last;

  assign g       = {wbuf_gnt, ifill_gnt, dfill_gnt};
  assign d       = {wbuf_done, ifill_done, dfill_done};
  assign at_last = (beat_idx == CNT_W'(BEATS - 1));

  p_onehot_gnt_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(g));

  p_prio_d_r3: assert property (@(posedge clk) disable iff (rst)
    (g == 3'b000 && dfill_req) |=> dfill_gnt);

  p_prio_i_r3: assert property (@(posedge clk) disable iff (rst)
    (g == 3'b000 && !dfill_req && ifill_req) |=> ifill_gnt);

  p_beat_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (g != 3'b000 && !ext_rdy) |=> $stable(beat_idx));

  p_beat_step_r5: assert property (@(posedge clk) disable iff (rst)
    (g != 3'b000 && ext_rdy && !at_last) |=> (beat_idx == $past(beat_idx) + 1'b1));

  p_grant_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (g != 3'b000 && !(ext_rdy && at_last)) |=> (g == $past(g)));

  p_done_class_r7: assert property (@(posedge clk) disable iff (rst)
    (g != 3'b000 && ext_rdy && at_last) |=> (d == $past(g) && g == 3'b000));

  p_done_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(d));

  p_dir_fill_r8: assert property (@(posedge clk) disable iff (rst)
    (dfill_gnt || ifill_gnt) |-> (bus_dir == 2'b01 && !wbuf_pop));

  p_dir_write_r8: assert property (@(posedge clk) disable iff (rst)
    wbuf_gnt |-> (bus_dir == 2'b10 && !cache_we));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (g == 3'b000) |-> (bus_dir == 2'b00 && !xfer_act && !cache_we && !wbuf_pop));

endmodule

bind fwarb_top fwarb_checker #(.BEATS(BEATS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dfill_req  (dfill_req),
  .ifill_req  (ifill_req),
  .dfill_gnt  (dfill_gnt),
  .ifill_gnt  (ifill_gnt),
  .wbuf_gnt   (wbuf_gnt),
  .dfill_done (dfill_done),
  .ifill_done (ifill_done),
  .wbuf_done  (wbuf_done),
  .ext_rdy    (ext_rdy),
  .xfer_act   (xfer_act),
  .bus_dir    (bus_dir),
  .beat_idx   (beat_idx),
  .cache_we   (cache_we),
  .wbuf_pop   (wbuf_pop)
);

// File: tb/tb_fwarb_top.sv
module tb_fwarb_top;

  localparam int CLK_P = 10;
  localparam int WDOG  = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dfill_req = 1'b0, ifill_req = 1'b0, wbuf_req = 1'b0;
  logic        dfill_gnt, ifill_gnt, wbuf_gnt;
  logic        dfill_done, ifill_done, wbuf_done;
  logic        ext_rdy = 1'b1;
  logic [63:0] ext_rdata = '0, wbuf_data = '0;
  logic        xfer_act;
  logic [1:0]  bus_dir;
  logic [1:0]  beat_idx;
  logic [63:0] cache_wdata, ext_wdata;
  logic        cache_we, wbuf_pop;

  fwarb_top dut (
    .clk(clk), .rst(rst),
    .dfill_req(dfill_req), .ifill_req(ifill_req), .wbuf_req(wbuf_req),
    .dfill_gnt(dfill_gnt), .ifill_gnt(ifill_gnt), .wbuf_gnt(wbuf_gnt),
    .dfill_done(dfill_done), .ifill_done(ifill_done), .wbuf_done(wbuf_done),
    .ext_rdy(ext_rdy), .ext_rdata(ext_rdata), .wbuf_data(wbuf_data),
    .xfer_act(xfer_act), .bus_dir(bus_dir), .beat_idx(beat_idx),
    .cache_wdata(cache_wdata), .cache_we(cache_we),
    .wbuf_pop(wbuf_pop), .ext_wdata(ext_wdata)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int b2b   = 0;
  int bcount = 0;
  bit stall = 1'b0;
  bit done_run = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [2:0] prev_g = '0, prev_d = '0;
  int exp_q[$];

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // external side and write buffer stimulus, updated after each rising edge
  always @(posedge clk) begin
    cyc++;
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ext_rdy   <= stall ? lfsr[0] : 1'b1;
    ext_rdata <= {32'hF00D_0000, 32'(cyc)};
    wbuf_data <= {32'hBEEF_0000, ~32'(cyc)};
    if (cyc > WDOG) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WDOG);
      finish_run();
    end
  end

  // requesters drop their request on seeing their own done pulse
  always @(negedge clk) begin
    if (dfill_done) dfill_req = 1'b0;
    if (ifill_done) ifill_req = 1'b0;
    if (wbuf_done)  wbuf_req  = 1'b0;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    logic [2:0] g, d;
    if (!rst) begin
      g = {wbuf_gnt, ifill_gnt, dfill_gnt};
      d = {wbuf_done, ifill_done, dfill_done};
      chk($countones(g) <= 1, "R2 single grant", 64'(g), 64'(0));
      if (g != 3'b000 && prev_g == 3'b000) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected grant", 64'(g), 64'(0));
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(g == 3'(1 << e), "R3 grant order", 64'(g), 64'(1 << e));
        end
        if (prev_d != 3'b000) b2b++;
        bcount = 0;
      end
      if (prev_g != 3'b000 && g != 3'b000)
        chk(g == prev_g, "R6 grant locked", 64'(g), 64'(prev_g));
      if (g != 3'b000) begin
        chk(bus_dir == (g[2] ? 2'b10 : 2'b01), "R8 direction", 64'(bus_dir),
            64'(g[2] ? 2 : 1));
        chk(xfer_act, "R5 active flag", 64'(xfer_act), 64'(1));
        chk(beat_idx == 2'(bcount), "R5 beat index", 64'(beat_idx), 64'(bcount));
        if (ext_rdy) begin
          if (g[2]) begin
            chk(wbuf_pop && !cache_we, "R8 write strobe", {cache_we, wbuf_pop}, 64'b01);
            chk(ext_wdata == wbuf_data, "R8 write data", ext_wdata, wbuf_data);
          end else begin
            chk(cache_we && !wbuf_pop, "R8 fill strobe", {cache_we, wbuf_pop}, 64'b10);
            chk(cache_wdata == ext_rdata, "R8 fill data", cache_wdata, ext_rdata);
          end
          bcount++;
        end else begin
          chk(!cache_we && !wbuf_pop, "R5 stall strobes", {cache_we, wbuf_pop}, 64'b00);
        end
      end else begin
        chk(bus_dir == 2'b00 && !xfer_act && !cache_we && !wbuf_pop, "R10 idle bus",
            {bus_dir, xfer_act, cache_we, wbuf_pop}, 64'(0));
      end
      if (d != 3'b000) begin
        chk(d == prev_g, "R7 done class", 64'(d), 64'(prev_g));
        chk(g == 3'b000, "R7 grants low on done", 64'(g), 64'(0));
        chk(bcount == 4, "R5 four beats", 64'(bcount), 64'(4));
      end
      if (prev_g != 3'b000 && g == 3'b000)
        chk(d == prev_g, "R7 done on release", 64'(d), 64'(prev_g));
      prev_g = g;
      prev_d = d;
    end
  end

  task automatic wait_quiet();
    do @(negedge clk);
    while (exp_q.size() != 0 || xfer_act || dfill_req || ifill_req || wbuf_req);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({dfill_gnt, ifill_gnt, wbuf_gnt} == 3'b000, "R1 grants in reset",
        {dfill_gnt, ifill_gnt, wbuf_gnt}, 64'(0));
    chk({dfill_done, ifill_done, wbuf_done} == 3'b000, "R1 done in reset",
        {dfill_done, ifill_done, wbuf_done}, 64'(0));
    chk(bus_dir == 2'b00 && !xfer_act && !cache_we && !wbuf_pop, "R1 bus in reset",
        {bus_dir, xfer_act, cache_we, wbuf_pop}, 64'(0));
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // lone data fill, no stalls; R4 grant latency
    dfill_req = 1'b1;
    exp_q.push_back(0);
    @(negedge clk);
    chk(dfill_gnt, "R4 grant next cycle", 64'(dfill_gnt), 64'(1));
    wait_quiet();

    // lone write with random stalls (R5, R8)
    stall = 1'b1;
    wbuf_req = 1'b1;
    exp_q.push_back(2);
    wait_quiet();

    // all three at once: priority and back-to-back re-arbitration (R3, R9)
    b2b = 0;
    dfill_req = 1'b1; ifill_req = 1'b1; wbuf_req = 1'b1;
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2);
    wait_quiet();
    chk(b2b == 2, "R9 back-to-back grants", 64'(b2b), 64'(2));

    // data fill arrives mid write burst: no preemption (R6)
    stall = 1'b0;
    b2b = 0;
    wbuf_req = 1'b1;
    exp_q.push_back(2);
    repeat (2) @(negedge clk);
    dfill_req = 1'b1;
    exp_q.push_back(0);
    wait_quiet();
    chk(b2b == 1, "R9 grant after done", 64'(b2b), 64'(1));

    // instruction fill against write buffer (R3)
    stall = 1'b1;
    ifill_req = 1'b1; wbuf_req = 1'b1;
    exp_q.push_back(1); exp_q.push_back(2);
    wait_quiet();

    // quiet stretch (R10)
    repeat (8) @(negedge clk);
    chk({dfill_gnt, ifill_gnt, wbuf_gnt} == 3'b000 && bus_dir == 2'b00,
        "R10 idle after traffic", {dfill_gnt, ifill_gnt, wbuf_gnt, bus_dir}, 64'(0));

    finish_run();
  end

endmodule